// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches a wide set of general-purpose input pins, organised as banks of 32, and records transitions on them in a sticky status register. Every pin has two enables, one for rising transitions and one for falling transitions. Setting both enables catches either direction, and clearing both turns detection off. The pin inputs are asynchronous. A two-flop synchroniser brings them into the clock domain, and a transition is found by comparing each synchronised level with its value one cycle earlier.

Software reaches the registers through a plain register bus: an address, a write enable, write data, and registered read data. To acknowledge an event, software writes a one to its status bit. Zero bits in that write leave the status alone. Pins 0 and 1 each drive an interrupt output of their own. Every status bit from pin 2 upward is ORed into a single shared interrupt output, so the dedicated pins never appear on the shared line.

The bank count and the number of pins in the last bank are parameters. With the defaults there are four banks, and the last bank holds 25 pins. Pins that do not exist in a configuration have enable, status and level bits that read as zero.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, all enable bits, all status bits, `rdata_o` and all three interrupt outputs are 0.
- R2: A pin whose rising enable is 1 sets its status bit on a low-to-high transition. A pin whose rising enable is 1 and whose falling enable is 0 does not set its status bit on a high-to-low transition.
- R3: A pin whose falling enable is 1 sets its status bit on a high-to-low transition. A pin whose falling enable is 1 and whose rising enable is 0 does not set its status bit on a low-to-high transition.
- R4: With both enables set, a pin sets its status bit on either transition. With neither enable set, a pin never sets its status bit.
- R5: Writing the status register clears exactly those bits written as 1. Bits written as 0 keep their value, and a write of all zeros changes nothing.
- R6: If a transition is detected on a pin in the same cycle that its status bit is written with 1, the bit stays set.
- R7: `irq0_o` equals the status bit of pin 0 and `irq1_o` equals the status bit of pin 1. Each stays high until software clears its bit.
- R8: `irq_shared_o` is high exactly when any status bit of pin 2 or above is set. The status bits of pins 0 and 1 never raise it.
- R9: Enable, status and level bits of pins beyond the configured count always read as 0, and writes to them have no effect. With the defaults, bank 3 exposes only bits 24..0.
- R10: The address is {kind[1:0], bank[BANK_W-1:0]}. Kind 0 is the rising enable, kind 1 the falling enable, kind 2 the status (write one to clear) and kind 3 the read-only synchronised pin level. `rdata_o` shows the register addressed in the previous cycle.
- R11: For a pin change applied before clock edge 1, the status bit and any interrupt output it drives are still 0 after edge 2 and are 1 after edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_BANKS*32 | Asynchronous pin inputs, pin n on bit n |
| we_i | input | 1 | Register write strobe |
| addr_i | input | BANK_W+2 | Register address {kind, bank} |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Registered read data |
| irq0_o | output | 1 | Interrupt for pin 0 |
| irq1_o | output | 1 | Interrupt for pin 1 |
| irq_shared_o | output | 1 | Interrupt for all pins from 2 upward |

## Verification
The hardest case to reach from the ports is the collision between a newly detected transition and a write-one-to-clear of the same bit. The detection pulse lasts one cycle, and it falls three clock edges after the pin change. The bench first latches an event on a pin that has both enables set. It then toggles the pin again at a falling clock edge, counts two rising edges, and drives the clearing write so that the third rising edge captures it. The bit must still read as set. A plain clear that follows must then remove it.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int BANK_BITS = 32;

  typedef enum logic [1:0] {
    REG_RISE  = 2'd0,
    REG_FALL  = 2'd1,
    REG_STAT  = 2'd2,
    REG_LEVEL = 2'd3
  } reg_kind_e;

  // Bits of a bank that map to real pins.
  function automatic logic [BANK_BITS-1:0] bank_valid(int bank, int nbanks, int last_pins);
    logic [BANK_BITS-1:0] m;
    m = '0;
    for (int i = 0; i < BANK_BITS; i++)
      if (bank < nbanks - 1 || (bank == nbanks - 1 && i < last_pins)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter logic [BANK_BITS-1:0] VALID = '1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BANK_BITS-1:0] lvl_i,
  input  logic                 wr_i,
  input  reg_kind_e            kind_i,
  input  logic [BANK_BITS-1:0] wdata_i,
  output logic [BANK_BITS-1:0] rise_en_o,
  output logic [BANK_BITS-1:0] fall_en_o,
  output logic [BANK_BITS-1:0] stat_o,
  output logic [BANK_BITS-1:0] lvl_o
);
  logic [BANK_BITS-1:0] prev_q, ren_q, fen_q, stat_q, hit, clr;

  assign hit = ((lvl_i & ~prev_q & ren_q) | (~lvl_i & prev_q & fen_q)) & VALID;
  assign clr = (wr_i && kind_i == REG_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl_i;
      if (wr_i && kind_i == REG_RISE) ren_q <= wdata_i & VALID;
      if (wr_i && kind_i == REG_FALL) fen_q <= wdata_i & VALID;
      // new event wins over a simultaneous clear
      stat_q <= (stat_q & ~clr) | hit;
    end
  end

  assign rise_en_o = ren_q;
  assign fall_en_o = fen_q;
  assign stat_o    = stat_q;
  assign lvl_o     = lvl_i & VALID;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS      = 4,
  parameter int LAST_BANK_PINS = 25,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W = BANK_W + 2,
  localparam int NUM_W  = NUM_BANKS * BANK_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_W-1:0]     pins_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BANK_BITS-1:0] wdata_i,
  output logic [BANK_BITS-1:0] rdata_o,
  output logic                 irq0_o,
  output logic                 irq1_o,
  output logic                 irq_shared_o
);
  localparam int NUM_SLOTS = 1 << BANK_W;

  logic [NUM_W-1:0]     lvl_sync;
  logic [NUM_W-1:0]     stat_q, en_any;
  logic [BANK_W-1:0]    bank_idx;
  reg_kind_e            kind;
  logic [BANK_BITS-1:0] ren_b [NUM_SLOTS];
  logic [BANK_BITS-1:0] fen_b [NUM_SLOTS];
  logic [BANK_BITS-1:0] stat_b[NUM_SLOTS];
  logic [BANK_BITS-1:0] lvl_b [NUM_SLOTS];
  logic [BANK_BITS-1:0] rd_next;

  assign bank_idx = addr_i[BANK_W-1:0];
  assign kind     = reg_kind_e'(addr_i[ADDR_W-1 -: 2]);

  gpio_sync #(.W(NUM_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (lvl_sync)
  );

  for (genvar b = 0; b < NUM_SLOTS; b++) begin : g_bank
    if (b < NUM_BANKS) begin : g_real
      gpio_edge_bank #(
        .VALID(bank_valid(b, NUM_BANKS, LAST_BANK_PINS))
      ) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .lvl_i    (lvl_sync[b*BANK_BITS +: BANK_BITS]),
        .wr_i     (we_i && bank_idx == BANK_W'(b)),
        .kind_i   (kind),
        .wdata_i  (wdata_i),
        .rise_en_o(ren_b[b]),
        .fall_en_o(fen_b[b]),
        .stat_o   (stat_b[b]),
        .lvl_o    (lvl_b[b])
      );
      assign stat_q[b*BANK_BITS +: BANK_BITS] = stat_b[b];
      assign en_any[b*BANK_BITS +: BANK_BITS] = ren_b[b] | fen_b[b];
    end else begin : g_pad
      assign ren_b[b]  = '0;
      assign fen_b[b]  = '0;
      assign stat_b[b] = '0;
      assign lvl_b[b]  = '0;
    end
  end

  always_comb begin
    unique case (kind)
      REG_RISE:  rd_next = ren_b[bank_idx];
      REG_FALL:  rd_next = fen_b[bank_idx];
      REG_STAT:  rd_next = stat_b[bank_idx];
      default:   rd_next = lvl_b[bank_idx];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_next;
  end

  assign irq0_o       = stat_q[0];
  assign irq1_o       = stat_q[1];
  assign irq_shared_o = |stat_q[NUM_W-1:2];
endmodule

module gpio_edge_irq_chk
  import gpio_edge_pkg::*;
#(
  parameter int NUM_BANKS      = 4,
  parameter int LAST_BANK_PINS = 25,
  parameter int ADDR_W         = 4,
  parameter int NUM_W          = 128
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [BANK_BITS-1:0] wdata_i,
  input logic [BANK_BITS-1:0] rdata_o,
  input logic                 irq0_o,
  input logic                 irq_shared_o,
  input logic [NUM_W-1:0]     en_any
);
  localparam logic [BANK_BITS-1:0] LAST_MASK = bank_valid(NUM_BANKS - 1, NUM_BANKS, LAST_BANK_PINS);
  localparam logic [ADDR_W-1:0]    LAST_REN  = ADDR_W'(NUM_BANKS - 1);
  localparam logic [ADDR_W-1:0]    STAT0     = ADDR_W'(2) << (ADDR_W - 2);

  // R7: pin 0 interrupt is sticky until a clearing write
  p_sticky_irq0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq0_o && !(we_i && addr_i == STAT0 && wdata_i[0]) |=> irq0_o);

  // R2: pin 0 can only latch an event while an enable was set
  p_irq0_needs_enable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq0_o) |-> $past(en_any[0]));

  // R8: shared line rises only from an enabled pin at 2 or above
  p_shared_needs_enable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_shared_o) |-> $past(|en_any[NUM_W-1:2]));

  // R9: missing pins of the last bank read as zero
  p_invalid_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(addr_i) == LAST_REN) |-> ((rdata_o & ~LAST_MASK) == '0));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
  .NUM_BANKS     (NUM_BANKS),
  .LAST_BANK_PINS(LAST_BANK_PINS),
  .ADDR_W        (ADDR_W),
  .NUM_W         (NUM_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .irq0_o      (irq0_o),
  .irq_shared_o(irq_shared_o),
  .en_any      (en_any)
);

// File: tb/gpio_edge_irq_bench.sv
module gpio_edge_irq_bench;
  localparam int NB = 4;
  localparam int NW = NB * 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NW-1:0] pins = '0;
  logic          we = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq0, irq1, irq_sh;
  int            checks = 0;
  int            errors = 0;

  always #10 clk = ~clk;

  gpio_edge_irq u_gpio_edge_irq (
    .clk_i(clk), .rst_ni(rst_ni), .pins_i(pins), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq0_o(irq0), .irq1_o(irq1),
    .irq_shared_o(irq_sh)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int kind, int bank, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = {kind[1:0], bank[1:0]}; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(int kind, int bank, output logic [31:0] d);
    @(negedge clk);
    we = 1'b0; addr = {kind[1:0], bank[1:0]};
    @(negedge clk);
    d = rdata;
  endtask

  task automatic set_pin(int idx, logic v);
    @(negedge clk);
    pins[idx] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_all();
    for (int b = 0; b < NB; b++) wr(2, b, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq0", {31'd0, irq0}, 0);
    chk("R1 irq1", {31'd0, irq1}, 0);
    chk("R1 shared", {31'd0, irq_sh}, 0);
    chk("R1 rdata", rdata, 0);
    for (int b = 0; b < NB; b++) begin
      rd(2, b, d); chk("R1 status", d, 0);
      rd(0, b, d); chk("R1 rise en", d, 0);
      rd(1, b, d); chk("R1 fall en", d, 0);
    end
  endtask

  task automatic t_latency_pin0();
    wr(0, 0, 32'h1);
    @(negedge clk); pins[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R11 after edge 2", {31'd0, irq0}, 0);
    @(negedge clk);
    chk("R11 after edge 3", {31'd0, irq0}, 1);
    repeat (5) @(negedge clk);
    chk("R7 irq0 sticky", {31'd0, irq0}, 1);
    chk("R7 irq1 quiet", {31'd0, irq1}, 0);
    chk("R8 pin0 not shared", {31'd0, irq_sh}, 0);
    wr(2, 0, 32'h1);
    chk("R7 irq0 cleared", {31'd0, irq0}, 0);
  endtask

  task automatic t_pin1();
    wr(1, 0, 32'h2);
    set_pin(1, 1'b1);
    chk("R7 irq1 no rise", {31'd0, irq1}, 0);
    set_pin(1, 1'b0);
    chk("R7 irq1 on fall", {31'd0, irq1}, 1);
    chk("R8 pin1 not shared", {31'd0, irq_sh}, 0);
    wr(2, 0, 32'h2);
    chk("R7 irq1 cleared", {31'd0, irq1}, 0);
  endtask

  task automatic t_rise_fall_both();
    logic [31:0] d;
    wr(0, 0, 32'h0000_00A0); // rise: pins 5, 7
    wr(1, 0, 32'h0000_00C0); // fall: pins 6, 7
    set_pin(5, 1'b1); set_pin(6, 1'b1); set_pin(7, 1'b1); set_pin(8, 1'b1);
    rd(2, 0, d); chk("R2 R3 R4 after rises", d, 32'h0000_00A0);
    chk("R8 shared set", {31'd0, irq_sh}, 1);
    wr(2, 0, 32'hFFFF_FFFF);
    set_pin(5, 1'b0); set_pin(6, 1'b0); set_pin(7, 1'b0); set_pin(8, 1'b0);
    rd(2, 0, d); chk("R2 R3 R4 after falls", d, 32'h0000_00C0);
    wr(2, 0, 32'hFFFF_FFFF);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    set_pin(5, 1'b1); set_pin(7, 1'b1);
    rd(2, 0, d); chk("R5 setup", d, 32'h0000_00A0);
    wr(2, 0, 32'h0);
    rd(2, 0, d); chk("R5 zero write", d, 32'h0000_00A0);
    wr(2, 0, 32'h0000_0020);
    rd(2, 0, d); chk("R5 partial clear", d, 32'h0000_0080);
    wr(2, 0, 32'hFFFF_FFFF);
    rd(2, 0, d); chk("R5 full clear", d, 0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    wr(0, 0, 32'h200); wr(1, 0, 32'h200);
    set_pin(9, 1'b1);
    @(negedge clk); pins[9] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); we = 1'b1; addr = {2'd2, 2'd0}; wdata = 32'h200;
    @(negedge clk); we = 1'b0; wdata = '0;
    rd(2, 0, d); chk("R6 event kept", d & 32'h200, 32'h200);
    wr(2, 0, 32'h200);
    rd(2, 0, d); chk("R6 later clear", d & 32'h200, 0);
  endtask

  task automatic t_shared();
    logic [31:0] d;
    clear_all();
    chk("R8 idle", {31'd0, irq_sh}, 0);
    wr(0, 2, 32'h40); // pin 70
    set_pin(70, 1'b1);
    chk("R8 bank 2 pin", {31'd0, irq_sh}, 1);
    rd(2, 2, d); chk("R10 bank 2 status", d, 32'h40);
    rd(3, 2, d); chk("R10 level read", d & 32'h40, 32'h40);
    wr(2, 2, 32'h40);
    chk("R8 cleared", {31'd0, irq_sh}, 0);
  endtask

  task automatic t_missing();
    logic [31:0] d;
    wr(0, 3, 32'hFFFF_FFFF);
    wr(1, 3, 32'hFFFF_FFFF);
    rd(0, 3, d); chk("R9 rise en mask", d, 32'h01FF_FFFF);
    rd(1, 3, d); chk("R9 fall en mask", d, 32'h01FF_FFFF);
    set_pin(127, 1'b1); set_pin(127, 1'b0);
    rd(2, 3, d); chk("R9 status missing pin", d, 0);
    chk("R9 no shared irq", {31'd0, irq_sh}, 0);
    set_pin(127, 1'b1); set_pin(96, 1'b1);
    rd(3, 3, d); chk("R9 level mask", d, 32'h0000_0001);
    rd(2, 3, d); chk("R9 valid pin 96", d, 32'h0000_0001);
    clear_all();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency_pin0();
    t_pin1();
    t_rise_fall_both();
    t_w1c();
    t_collision();
    t_shared();
    t_missing();
    finish_run();
  end
endmodule